// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the fetch address of a small 8-bit controller core whose program space is 1024 words, together with a five-entry hardware stack of return addresses. The instruction decoder drives one-cycle strobes. These strobes ask for a sequential advance, an absolute jump, a subroutine call, a return, a write of the accumulator into the low byte of the counter, or an addition of the accumulator to that low byte. The block then produces the next fetch address on the following clock edge.

Writing the counter as a data register always zeroes its two upper bits, so computed jumps reach only the first 256 words. Any load that breaks sequential flow raises a registered request for one extra instruction cycle. The fetch stage uses that request to discard the word it has already fetched. The stack is circular. A call made when five returns are already pending overwrites the oldest one, and no error is reported.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_addr` becomes 0 and `stall_req` becomes 0, and the stack is emptied.
- R2: With `adv_en` as the only strobe, `fetch_addr` increments by one on the next edge and wraps from 0x3FF to 0x000. With no strobe, it holds its value.
- R3: A jump (`jmp_en`) loads all 10 bits of `imm_tgt` into `fetch_addr`.
- R4: A call (`call_en`) loads `imm_tgt` and pushes the value `fetch_addr`+1 (modulo 1024) onto the stack.
- R5: A return (`ret_en`) loads the most recently pushed entry that has not yet been popped, and removes that entry from the stack.
- R6: A low-byte write (`wr_en`) sets `fetch_addr` to `{2'b00, acc_val}`.
- R7: A low-byte add (`add_en`) sets `fetch_addr` to `{2'b00, (fetch_addr[7:0] + acc_val) mod 256}`.
- R8: `stall_req` is high for the cycle that follows any jump, call, return, write or add. It is low after an advance or an idle cycle.
- R9: Up to five nested calls are followed by matching returns in last-in, first-out order.
- R10: A sixth push with no pop between overwrites the oldest entry. The stack pointer wraps modulo 5, so the sixth pop in a row returns the entry written by the sixth push again.
- R11: When several strobes are high at once, the one that takes effect is chosen in this order: return first, then call, jump, add, write, and advance last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Sequential advance strobe |
| jmp_en | input | 1 | Absolute jump strobe |
| call_en | input | 1 | Call strobe (push return address) |
| ret_en | input | 1 | Return strobe (pop return address) |
| wr_en | input | 1 | Write accumulator into counter low byte |
| add_en | input | 1 | Add accumulator to counter low byte |
| imm_tgt | input | 10 | Immediate target address |
| acc_val | input | 8 | Accumulator value |
| fetch_addr | output | 10 | Current fetch address |
| stall_req | output | 1 | Request for one extra instruction cycle |

## Verification
The bench builds the block with its default values: a 10-bit counter, an 8-bit writable low byte and a stack depth of 5. With a 10-bit counter, the wrap from 0x3FF back to zero and the clearing of bits 8 and 9 take only a few strobes to reach. With a depth of 5, six calls in a row are enough to overflow the stack, so the bench can observe the overwrite of the oldest entry and the wrapped pops.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_STEP  = 3'd1,
    OP_WRLO  = 3'd2,
    OP_ADDLO = 3'd3,
    OP_JUMP  = 3'd4,
    OP_CALL  = 3'd5,
    OP_RET   = 3'd6
  } pc_op_e;
endpackage

// File: rtl/pc_op_select.sv
module pc_op_select
  import pc_pkg::*;
(
  input  logic   adv_en,
  input  logic   jmp_en,
  input  logic   call_en,
  input  logic   ret_en,
  input  logic   wr_en,
  input  logic   add_en,
  output pc_op_e op
);
  // Fixed priority: return, call, jump, add, write, advance (R11)
  always_comb begin
    if (ret_en)       op = OP_RET;
    else if (call_en) op = OP_CALL;
    else if (jmp_en)  op = OP_JUMP;
    else if (add_en)  op = OP_ADDLO;
    else if (wr_en)   op = OP_WRLO;
    else if (adv_en)  op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/return_stack.sv
module return_stack #(
  parameter int DEPTH = 5,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp, sp_inc, sp_dec;

  // Circular pointer, modulo DEPTH
  always_comb begin
    sp_inc = (sp == LAST) ? '0 : sp + SP_W'(1);
    sp_dec = (sp == '0) ? LAST : sp - SP_W'(1);
  end

  // Storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[sp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp_inc;
    else if (pop)  sp <= sp_dec;
  end

  assign top = mem[sp_dec];

  // R10
  sp_range_chk: assert property (@(posedge clk) disable iff (rst)
    sp <= LAST);

  // R10
  sp_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (push && sp == LAST) |=> sp == '0);
endmodule

// File: rtl/pc_stack_unit.sv
module pc_stack_unit
  import pc_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int LOW_W = 8,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_en,
  input  logic             jmp_en,
  input  logic             call_en,
  input  logic             ret_en,
  input  logic             wr_en,
  input  logic             add_en,
  input  logic [PC_W-1:0]  imm_tgt,
  input  logic [LOW_W-1:0] acc_val,
  output logic [PC_W-1:0]  fetch_addr,
  output logic             stall_req
);
  pc_op_e          op;
  logic [PC_W-1:0] pc_q, pc_d, pc_plus1, stk_top;
  logic [LOW_W-1:0] low_sum;
  logic            nonseq;

  pc_op_select u_sel (
    .adv_en (adv_en), .jmp_en (jmp_en), .call_en(call_en),
    .ret_en (ret_en), .wr_en  (wr_en),  .add_en (add_en),
    .op     (op)
  );

  assign pc_plus1 = pc_q + PC_W'(1);
  assign low_sum  = pc_q[LOW_W-1:0] + acc_val;
  assign nonseq   = (op != OP_HOLD) && (op != OP_STEP);

  return_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stk (
    .clk (clk),
    .rst (rst),
    .push(op == OP_CALL),
    .pop (op == OP_RET),
    .din (pc_plus1),
    .top (stk_top)
  );

  // Data-register writes zero-extend, clearing the page bits
  always_comb begin
    unique case (op)
      OP_RET:          pc_d = stk_top;
      OP_CALL, OP_JUMP: pc_d = imm_tgt;
      OP_ADDLO:        pc_d = PC_W'(low_sum);
      OP_WRLO:         pc_d = PC_W'(acc_val);
      OP_STEP:         pc_d = pc_plus1;
      default:         pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      stall_req <= 1'b0;
    end else begin
      pc_q      <= pc_d;
      stall_req <= nonseq;
    end
  end

  assign fetch_addr = pc_q;

  // R2
  adv_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !jmp_en && !call_en && !ret_en && !wr_en && !add_en)
      |=> fetch_addr == $past(fetch_addr) + PC_W'(1));

  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    (jmp_en && !call_en && !ret_en) |=> fetch_addr == $past(imm_tgt));

  // R5
  ret_load_chk: assert property (@(posedge clk) disable iff (rst)
    ret_en |=> fetch_addr == $past(stk_top));

  // R6
  wr_page_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || add_en) && !jmp_en && !call_en && !ret_en)
      |=> fetch_addr[PC_W-1:LOW_W] == '0);

  // R8
  stall_set_chk: assert property (@(posedge clk) disable iff (rst)
    (jmp_en || call_en || ret_en || wr_en || add_en) |=> stall_req);

  // R8
  stall_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(jmp_en || call_en || ret_en || wr_en || add_en) |=> !stall_req);
endmodule

// File: tb/tb_pc_stack_unit.sv
`timescale 1ns/1ps
module tb_pc_stack_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv_en = 0, jmp_en = 0, call_en = 0, ret_en = 0, wr_en = 0, add_en = 0;
  logic [9:0] imm_tgt = '0;
  logic [7:0] acc_val = '0;
  logic [9:0] fetch_addr;
  logic       stall_req;

  always #2.5 clk = ~clk;

  pc_stack_unit dut (.*);

  typedef struct { logic [9:0] pc; logic ex; string tag; } exp_t;
  exp_t q[$];
  int n_run = 0, n_fail = 0;

  // Reference model state
  logic [9:0] m_pc = '0;
  logic [9:0] m_stk [5];
  int         m_sp = 0;

  task automatic check(input string tag, input logic [9:0] pc_a, input logic [9:0] pc_e,
                       input logic ex_a, input logic ex_e);
    n_run++;
    if (pc_a !== pc_e || ex_a !== ex_e) begin
      n_fail++;
      $display("FAIL %s: pc=%h stall=%b expected pc=%h stall=%b", tag, pc_a, ex_a, pc_e, ex_e);
    end
  endtask

  // Driver: applies one strobe set and queues the expected result
  task automatic drive(input logic v, j, c, r, w, a, input logic [9:0] im,
                       input logic [7:0] ac, input string tag);
    exp_t e;
    @(negedge clk);
    {adv_en, jmp_en, call_en, ret_en, wr_en, add_en} = {v, j, c, r, w, a};
    imm_tgt = im; acc_val = ac;
    if (r) begin
      m_sp = (m_sp + 4) % 5;
      m_pc = m_stk[m_sp];
    end else if (c) begin
      m_stk[m_sp] = m_pc + 10'd1;
      m_sp = (m_sp + 1) % 5;
      m_pc = im;
    end else if (j) m_pc = im;
    else if (a) m_pc = {2'b00, 8'(m_pc[7:0] + ac)};
    else if (w) m_pc = {2'b00, ac};
    else if (v) m_pc = m_pc + 10'd1;
    e.pc = m_pc; e.ex = j | c | r | w | a; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(); drive(0,0,0,0,0,0,'0,'0,"R2 idle hold"); endtask

  // Monitor: compares after each active edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, fetch_addr, e.pc, stall_req, e.ex);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {adv_en, jmp_en, call_en, ret_en, wr_en, add_en} = '0;
    @(negedge clk);
    check("R1 reset state", fetch_addr, 10'h000, stall_req, 1'b0);
    rst = 1'b0;
    m_pc = '0; m_sp = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    do_reset();
    // R2 advance and hold
    drive(1,0,0,0,0,0,'0,'0,"R2 step");
    drive(1,0,0,0,0,0,'0,'0,"R2 step");
    idle();
    // R3 jump, R2 wrap
    drive(0,1,0,0,0,0,10'h3FE,'0,"R3 jump");
    drive(1,0,0,0,0,0,'0,'0,"R2 step");
    drive(1,0,0,0,0,0,'0,'0,"R2 wrap");
    // R6 write low byte clears page bits
    drive(0,1,0,0,0,0,10'h2A5,'0,"R3 jump");
    drive(0,0,0,0,1,0,'0,8'h80,"R6 write low");
    // R7 add with low-byte wrap
    drive(0,1,0,0,0,0,10'h3F0,'0,"R3 jump");
    drive(0,0,0,0,0,1,'0,8'h20,"R7 add wraps");
    drive(0,0,0,0,0,1,'0,8'h05,"R7 add");
    // R9 nested calls depth 5
    drive(0,1,0,0,0,0,10'h100,'0,"R3 jump");
    for (int i = 0; i < 5; i++) begin
      drive(0,0,1,0,0,0,10'(10'h200 + 10'(i) * 10'h40),'0,"R4 call");
      drive(1,0,0,0,0,0,'0,'0,"R2 step");
    end
    for (int i = 0; i < 5; i++) begin
      drive(0,0,0,1,0,0,'0,'0,"R5 R9 return");
      drive(1,0,0,0,0,0,'0,'0,"R2 step");
    end
    // R10 overflow: six calls then six returns
    drive(0,1,0,0,0,0,10'h010,'0,"R3 jump");
    for (int i = 0; i < 6; i++)
      drive(0,0,1,0,0,0,10'(10'h020 + 10'(i) * 10'h10),'0,"R4 call");
    for (int i = 0; i < 6; i++)
      drive(0,0,0,1,0,0,'0,'0,"R10 wrapped return");
    // R11 priority
    drive(0,1,0,0,0,0,10'h155,'0,"R3 jump");
    drive(0,0,1,0,0,0,10'h0AA,'0,"R4 call");
    drive(1,1,1,1,1,1,10'h3C3,8'h11,"R11 return wins");
    drive(1,1,1,0,1,1,10'h0C0,8'h11,"R11 call wins");
    drive(1,1,0,0,1,1,10'h1E1,8'h11,"R11 jump wins");
    drive(1,0,0,0,1,1,'0,8'h11,"R11 add wins");
    drive(1,0,0,0,1,0,'0,8'h7E,"R11 write wins");
    idle();
    idle();
    // R1 mid-run reset
    drive(0,1,0,0,0,0,10'h2FF,'0,"R3 jump");
    @(negedge clk);
    {adv_en, jmp_en, call_en, ret_en, wr_en, add_en} = '0;
    @(posedge clk); #2;
    do_reset();
    drive(1,0,0,0,0,0,'0,'0,"R1 R2 step after reset");
    idle();
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule